// File: doc/BRIEF.md
# Interrupt Expander with Mask Registers

This block gathers up to sixteen asynchronous interrupt lines from board peripherals into a single level-type, active-low interrupt for a host processor. Each line passes through a two-flop synchroniser. Its status bit is then set on a rising level and stays set until software clears it. A mask bit of 1 blocks the line from the output. A line is pending when its status bit is set and its mask bit is clear, and the output is driven low while any line is pending.

Status bits are cleared through a separate clear register. Each 1 written to that register forces the matching status bit to zero, and keeps it at zero until software writes the register back to 0. Software talks to the block over a simple 16-bit register bus. The same bus exposes three constant identification words and a code-version word, so that a driver can check that the board is present before it enables interrupts.

Top module: `irq_expander`

## Requirements
- R1: Reading address 0x0 returns 0xAAAA, address 0x1 returns 0x5555, address 0x2 returns 0xCAFE, and address 0x3 returns the CODE_VER parameter. The default for CODE_VER is 0x0102.
- R2: After reset, the mask register (address 0x5) reads 0xFFFF, the status register (address 0x4) reads 0x0000, the clear register (address 0x6) reads 0x0000, and irq_n is 1.
- R3: When source bit i rises and then stays high, status bit i reads 1 once three clock edges have passed. The bit stays 1 after the source falls again, until it is cleared.
- R4: irq_n is 0 exactly when (status AND NOT mask) is non-zero. irq_n changes on the same edge on which status or mask take their new values.
- R5: While bit i of the clear register is 1, status bit i stays 0, even if its source rises. After the clear bit is written back to 0, a source that is still high does not set the status bit again. Only a new rising level sets it.
- R6: Writing 0xFFFF to the clear register clears every status bit.
- R7: Reads of addresses 0x7 through 0xF return 0. Writes to addresses 0x0 through 0x4 change neither the read-back values nor irq_n.
- R8: The mask register reads back the value written to it. With mask 0x001F, pending bits 0 to 4 are blocked and higher bits are not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_in | input | 16 | Asynchronous interrupt sources |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address (halfword index) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, 0 when not selected |
| irq_n | output | 1 | Level interrupt to the host, active low |

## Verification
Single-bit pulses on the lowest and highest lines, together with a two-bit pulse, show that every line latches independently and holds after the source falls. Changing the mask between 0x001F, 0xFFFF and 0xFEFF, with the same status, shows that irq_n follows only the unmasked pending bits. A line that rises while its clear bit is held, and stays high after release, tells a correct edge-based latch apart from one that samples the level. An all-ones clear and writes to read-only or unmapped addresses cover the remaining cases.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_ID0  = 4'h0,
        RA_ID1  = 4'h1,
        RA_ID2  = 4'h2,
        RA_VER  = 4'h3,
        RA_STAT = 4'h4,
        RA_MASK = 4'h5,
        RA_CLR  = 4'h6
    } reg_addr_e;

    localparam logic [15:0] ID_WORD0 = 16'hAAAA;
    localparam logic [15:0] ID_WORD1 = 16'h5555;
    localparam logic [15:0] ID_WORD2 = 16'hCAFE;
endpackage

// File: rtl/irqx_sync.sv
module irqx_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, sync_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= async_in[i];
                sync_q <= meta_q;
            end
        end
        assign sync_out[i] = sync_q;
    end
endmodule

// File: rtl/irqx_core.sv
module irqx_core
    import irqx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      src_s,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      stat_o,
    output logic [W-1:0]      mask_o,
    output logic [W-1:0]      clr_o,
    output logic              irq_n_o
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] stat;
        logic [W-1:0] mask;
        logic [W-1:0] clr;
        logic         irq_n;
    } core_st_t;

    localparam core_st_t ST_RST = '{prev: '0, stat: '0, mask: '1, clr: '0, irq_n: 1'b1};

    core_st_t st_d, st_q;
    logic     wr_mask, wr_clr;

    assign wr_mask = bus_sel && bus_wr && (bus_addr == RA_MASK);
    assign wr_clr  = bus_sel && bus_wr && (bus_addr == RA_CLR);

    always_comb begin
        st_d = st_q;
        if (wr_mask) st_d.mask = bus_wdata;
        if (wr_clr)  st_d.clr  = bus_wdata;
        st_d.prev  = src_s;
        st_d.stat  = (st_q.stat | (src_s & ~st_q.prev)) & ~st_q.clr;
        st_d.irq_n = ~|(st_d.stat & ~st_d.mask);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_RST;
        else     st_q <= st_d;
    end

    assign stat_o  = st_q.stat;
    assign mask_o  = st_q.mask;
    assign clr_o   = st_q.clr;
    assign irq_n_o = st_q.irq_n;
endmodule

// File: rtl/irqx_rdmux.sv
module irqx_rdmux
    import irqx_pkg::*;
#(
    parameter int          W        = 16,
    parameter logic [15:0] CODE_VER = 16'h0102
) (
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      stat,
    input  logic [W-1:0]      mask,
    input  logic [W-1:0]      clr,
    output logic [W-1:0]      rdata
);
    always_comb begin
        rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                RA_ID0:  rdata = W'(ID_WORD0);
                RA_ID1:  rdata = W'(ID_WORD1);
                RA_ID2:  rdata = W'(ID_WORD2);
                RA_VER:  rdata = W'(CODE_VER);
                RA_STAT: rdata = stat;
                RA_MASK: rdata = mask;
                RA_CLR:  rdata = clr;
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_expander.sv
module irq_expander
    import irqx_pkg::*;
#(
    parameter int          W        = 16,
    parameter logic [15:0] CODE_VER = 16'h0102
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      src_in,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic              irq_n
);
    logic [W-1:0] src_s, stat_w, mask_w, clr_w;

    irqx_sync #(.W(W)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (src_in),
        .sync_out (src_s)
    );

    irqx_core #(.W(W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .src_s     (src_s),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .stat_o    (stat_w),
        .mask_o    (mask_w),
        .clr_o     (clr_w),
        .irq_n_o   (irq_n)
    );

    irqx_rdmux #(.W(W), .CODE_VER(CODE_VER)) u_rdmux (
        .bus_sel  (bus_sel),
        .bus_addr (bus_addr),
        .stat     (stat_w),
        .mask     (mask_w),
        .clr      (clr_w),
        .rdata    (bus_rdata)
    );
endmodule

// File: rtl/irqx_chk.sv
module irqx_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         bus_sel,
    input logic [3:0]   bus_addr,
    input logic [W-1:0] bus_rdata,
    input logic [W-1:0] stat,
    input logic [W-1:0] mask,
    input logic [W-1:0] clr,
    input logic         irq_n
);
    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
        irq_n == ((stat & ~mask) == '0)); // R4

    AST_CLR_FORCES_ZERO: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat & $past(clr)) == '0)); // R5

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(stat) & ~stat & ~$past(clr)) == '0)); // R3

    AST_ID_WORD: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_addr == 4'h2) |-> bus_rdata == W'(16'hCAFE)); // R1

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_addr >= 4'h7) |-> bus_rdata == '0); // R7
endmodule

bind irq_expander irqx_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .stat      (stat_w),
    .mask      (mask_w),
    .clr       (clr_w),
    .irq_n     (irq_n)
);

// File: tb/test_irq_expander.sv
module test_irq_expander;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] src_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_n;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    irq_expander i_irq_expander (
        .clk(clk), .rst(rst), .src_in(src_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse(input logic [15:0] bits);
        @(negedge clk);
        src_in = src_in | bits;
        idle(4);
        src_in = src_in & ~bits;
        idle(3);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(4'h5, v); chk("R2 mask", v, 16'hFFFF);
        rd(4'h4, v); chk("R2 status", v, 16'h0000);
        rd(4'h6, v); chk("R2 clear", v, 16'h0000);
        chk("R2 irq_n", {15'd0, irq_n}, 16'h0001);
    endtask

    task automatic t_ident;
        logic [15:0] v;
        rd(4'h0, v); chk("R1 id0", v, 16'hAAAA);
        rd(4'h1, v); chk("R1 id1", v, 16'h5555);
        rd(4'h2, v); chk("R1 id2", v, 16'hCAFE);
        rd(4'h3, v); chk("R1 ver", v, 16'h0102);
        wr(4'h0, 16'h1234); wr(4'h3, 16'h0000);
        rd(4'h0, v); chk("R7 id0 write ignored", v, 16'hAAAA);
        rd(4'h3, v); chk("R7 ver write ignored", v, 16'h0102);
    endtask

    task automatic t_latch;
        logic [15:0] v;
        wr(4'h5, 16'h0000);
        idle(1);
        chk("R4 no pending irq_n", {15'd0, irq_n}, 16'h0001);
        pulse(16'h0001);
        rd(4'h4, v); chk("R3 bit0 latched", v, 16'h0001);
        chk("R4 irq_n low", {15'd0, irq_n}, 16'h0000);
        pulse(16'h8100);
        rd(4'h4, v); chk("R3 bits 15,8 latched", v, 16'h8101);
    endtask

    task automatic t_mask;
        logic [15:0] v;
        wr(4'h5, 16'h001F);
        rd(4'h5, v); chk("R8 mask readback", v, 16'h001F);
        chk("R8 high bits still pending", {15'd0, irq_n}, 16'h0000);
        wr(4'h5, 16'hFFFF);
        chk("R4 all masked irq_n high", {15'd0, irq_n}, 16'h0001);
        wr(4'h4, 16'h0000);
        rd(4'h4, v); chk("R7 status write ignored", v, 16'h8101);
        chk("R7 irq_n unchanged", {15'd0, irq_n}, 16'h0001);
        wr(4'h5, 16'hFEFF);
        chk("R4 bit8 unmasked irq_n low", {15'd0, irq_n}, 16'h0000);
    endtask

    task automatic t_clear;
        logic [15:0] v;
        wr(4'h5, 16'h0000);
        wr(4'h6, 16'h0100);
        idle(1);
        rd(4'h4, v); chk("R5 bit8 cleared", v, 16'h8001);
        rd(4'h6, v); chk("R5 clear readback", v, 16'h0100);
        @(negedge clk); src_in = 16'h0100;
        idle(5);
        rd(4'h4, v); chk("R5 held clear blocks rise", v, 16'h8001);
        wr(4'h6, 16'h0000);
        idle(4);
        rd(4'h4, v); chk("R5 steady high no relatch", v, 16'h8001);
        src_in = 16'h0000; idle(4);
        pulse(16'h0100);
        rd(4'h4, v); chk("R5 new rise relatches", v, 16'h8101);
    endtask

    task automatic t_clear_all;
        logic [15:0] v;
        wr(4'h6, 16'hFFFF);
        idle(1);
        rd(4'h4, v); chk("R6 all cleared", v, 16'h0000);
        chk("R6 irq_n high", {15'd0, irq_n}, 16'h0001);
        wr(4'h6, 16'h0000);
    endtask

    task automatic t_unmapped;
        logic [15:0] v;
        rd(4'h7, v); chk("R7 addr 7 zero", v, 16'h0000);
        rd(4'hF, v); chk("R7 addr F zero", v, 16'h0000);
    endtask

    initial begin
        idle(3);
        @(negedge clk); rst = 1'b0;
        t_reset;
        t_ident;
        t_latch;
        t_mask;
        t_clear;
        t_clear_all;
        t_unmapped;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule